// File: doc/BRIEF.md
# Net Fault Injection Unit

This unit sits on one net of a design under test. The net is cut in two. The original driver feeds `orig_i`, and `inj_o` drives the loads. The unit normally passes the net straight through. When told to, it replaces the net with a faulty version: a constant low or high, the value from one cycle earlier, a one-cycle bit flip, or a pseudo-random value that emulates a floating (stuck-open) net.

Fault settings arrive as six bits. They move through a staging shift register, and the staging registers of neighbouring units form one serial chain. A separate update strobe copies the staged bits into the active pattern register. New settings can therefore be shifted in while the current ones keep acting, and a message that turns out to be bad never reaches the net. The six active bits hold two three-bit patterns, one for each injection phase. A phase select chooses between them, and an enable gates both.

The stuck-open value is the AND of those bits of an external LFSR bus that a per-unit mask parameter selects. A parameter can also cut the unit down to a single fault model, which gives a smaller multiplexer on the net.

Top module: `net_fiu`

## Requirements
- R1: A synchronous active-high reset clears the staging register and the active pattern register to zero. After reset, `chain_o` is 0 and `inj_o` equals `orig_i`.
- R2: Each cycle with `shift_en_i` high, the staging register shifts one place toward its MSB and takes `chain_i` into bit 0. `chain_o` is the staging MSB, so a bit appears there after six shifts. With `shift_en_i` low, the staging register holds its value.
- R3: The active pattern register loads the staging content only in a cycle with `update_i` high. Shifting without an update leaves the active fault on `inj_o` unchanged.
- R4: The effective code is active bits [2:0] when `phase_i`=0 and bits [5:3] when `phase_i`=1. With `inj_en_i` low, `inj_o` equals `orig_i` combinationally, whatever the pattern.
- R5: Code 000 (no fault) and the unused codes 110 and 111 pass `orig_i` through to `inj_o` unchanged.
- R6: Code 001 drives `inj_o` to 0 and code 010 drives `inj_o` to 1.
- R7: Code 011 drives `inj_o` with `orig_i` as it was one cycle earlier. The delay register samples every cycle, whatever the code, and reset clears it to 0.
- R8: Code 100 inverts `orig_i` only in the first cycle in which the effective code becomes 100, and passes `orig_i` in the cycles after that. If the effective code leaves 100 and later returns, the flip is armed again.
- R9: Code 101 drives `inj_o` with the AND of the `lfsr_i` bits whose mask-parameter bit is 1. An all-zero mask gives a constant 1.
- R10: When the model-restriction parameter names a single code, every other code passes `orig_i` through.
- R11: When `update_i` and `shift_en_i` are high in the same cycle, the active register receives the staging content from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| orig_i | input | 1 | Value from the net's original driver |
| inj_o | output | 1 | Value delivered to the net's loads |
| chain_i | input | 1 | Serial configuration bit from the previous unit |
| shift_en_i | input | 1 | Shift the staging register one place |
| chain_o | output | 1 | Staging MSB, to the next unit in the chain |
| update_i | input | 1 | Copy the staging register into the active pattern |
| phase_i | input | 1 | 0 selects pattern bits [2:0], 1 selects bits [5:3] |
| inj_en_i | input | 1 | Enables injection; when low the net passes through |
| lfsr_i | input | LFSR_W | Shared pseudo-random bus used for stuck-open |

## Verification
Directed patterns load each fault code into both phase slots.

- **Delay:** a toggling `orig_i` separates a one-cycle delay from plain pass-through.
- **Bit flip:** switching phases and the enable back and forth shows that the flip happens once per activation and is armed again.
- **Double buffering:** shifting new bits without an update shows that the active fault stays in place. Update and shift in the same cycle show which staging content is captured.
- **Reserved codes:** the two unused codes are loaded and must pass the net through.
- **Random stimulus:** randomly mixed shift, update, phase, enable, net and LFSR values, checked cycle by cycle against a bench model, catch ordering errors between the two registers. A second instance, restricted to stuck-open with an empty mask, covers the restriction and the constant-1 case.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

    localparam int PAT_W   = 3;
    localparam int NUM_PH  = 2;
    localparam int STAGE_W = PAT_W * NUM_PH;

    typedef enum logic [PAT_W-1:0] {
        F_NONE  = 3'd0,
        F_SA0   = 3'd1,
        F_SA1   = 3'd2,
        F_DLY   = 3'd3,
        F_SEU   = 3'd4,
        F_SOPEN = 3'd5,
        F_RSV6  = 3'd6,
        F_RSV7  = 3'd7
    } fault_e;

    typedef struct packed {
        logic [PAT_W-1:0] ph2;
        logic [PAT_W-1:0] ph1;
    } pat_pair_t;

    function automatic fault_e pick_phase(pat_pair_t p, logic ph2_sel, logic en);
        if (!en)
            return F_NONE;
        return ph2_sel ? fault_e'(p.ph2) : fault_e'(p.ph1);
    endfunction

endpackage

// File: rtl/fiu_pattern_regs.sv
module fiu_pattern_regs
    import fiu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      chain_i,
    input  logic      shift_en_i,
    input  logic      update_i,
    output logic      chain_o,
    output pat_pair_t pat_o
);

    logic [STAGE_W-1:0] sh_q;
    pat_pair_t          pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            pat_q <= '0;
        end else begin
            if (shift_en_i)
                sh_q <= {sh_q[STAGE_W-2:0], chain_i};
            if (update_i)
                pat_q <= pat_pair_t'(sh_q);
        end
    end

    assign chain_o = sh_q[STAGE_W-1];
    assign pat_o   = pat_q;

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en_i |=> (sh_q[0] == $past(chain_i)));

    // R2
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en_i |=> $stable(sh_q));

    // R3
    pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !update_i |=> $stable(pat_q));

    // R11
    pat_load_chk: assert property (@(posedge clk) disable iff (rst)
        update_i |=> (pat_q == pat_pair_t'($past(sh_q))));

endmodule

// File: rtl/fiu_fault_mux.sv
module fiu_fault_mux
    import fiu_pkg::*;
#(
    parameter int                LFSR_W     = 8,
    parameter logic [LFSR_W-1:0] SOPEN_MASK = 8'b0010_0101,
    parameter fault_e            ONLY_MODEL = F_NONE
) (
    input  logic              clk,
    input  logic              rst,
    input  fault_e            code_i,
    input  logic              orig_i,
    input  logic [LFSR_W-1:0] lfsr_i,
    output logic              inj_o
);

    fault_e code_lim;
    fault_e prev_q;
    logic   dly_q;
    logic   seu_first;
    logic   sopen_val;

    generate
        if (ONLY_MODEL == F_NONE) begin : g_all_models
            assign code_lim = code_i;
        end else begin : g_one_model
            assign code_lim = (code_i == ONLY_MODEL) ? code_i : F_NONE;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q  <= 1'b0;
            prev_q <= F_NONE;
        end else begin
            dly_q  <= orig_i;
            prev_q <= code_lim;
        end
    end

    assign seu_first = (code_lim == F_SEU) && (prev_q != F_SEU);
    assign sopen_val = &(lfsr_i | ~SOPEN_MASK);

    always_comb begin
        unique case (code_lim)
            F_SA0:   inj_o = 1'b0;
            F_SA1:   inj_o = 1'b1;
            F_DLY:   inj_o = dly_q;
            F_SEU:   inj_o = orig_i ^ seu_first;
            F_SOPEN: inj_o = sopen_val;
            default: inj_o = orig_i;
        endcase
    end

    // R5
    pass_none_chk: assert property (@(posedge clk) disable iff (rst)
        (code_lim == F_NONE) |-> (inj_o == orig_i));

    // R6
    stuck_low_chk: assert property (@(posedge clk) disable iff (rst)
        (code_lim == F_SA0) |-> !inj_o);

    // R6
    stuck_high_chk: assert property (@(posedge clk) disable iff (rst)
        (code_lim == F_SA1) |-> inj_o);

    // R7
    delay_val_chk: assert property (@(posedge clk) disable iff (rst)
        (code_lim == F_DLY && !$past(rst)) |-> (inj_o == $past(orig_i)));

    // R8
    seu_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (code_lim == F_SEU && $past(code_lim) != F_SEU && !$past(rst)) |-> (inj_o != orig_i));

    // R8
    seu_once_chk: assert property (@(posedge clk) disable iff (rst)
        (code_lim == F_SEU && $past(code_lim) == F_SEU && !$past(rst)) |-> (inj_o == orig_i));

endmodule

// File: rtl/net_fiu.sv
module net_fiu
    import fiu_pkg::*;
#(
    parameter int                LFSR_W     = 8,
    parameter logic [LFSR_W-1:0] SOPEN_MASK = 8'b0010_0101,
    parameter fault_e            ONLY_MODEL = F_NONE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              orig_i,
    output logic              inj_o,
    input  logic              chain_i,
    input  logic              shift_en_i,
    output logic              chain_o,
    input  logic              update_i,
    input  logic              phase_i,
    input  logic              inj_en_i,
    input  logic [LFSR_W-1:0] lfsr_i
);

    pat_pair_t active_pat;
    fault_e    eff_code;

    fiu_pattern_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .chain_i    (chain_i),
        .shift_en_i (shift_en_i),
        .update_i   (update_i),
        .chain_o    (chain_o),
        .pat_o      (active_pat)
    );

    assign eff_code = pick_phase(active_pat, phase_i, inj_en_i);

    fiu_fault_mux #(
        .LFSR_W     (LFSR_W),
        .SOPEN_MASK (SOPEN_MASK),
        .ONLY_MODEL (ONLY_MODEL)
    ) u_mux (
        .clk    (clk),
        .rst    (rst),
        .code_i (eff_code),
        .orig_i (orig_i),
        .lfsr_i (lfsr_i),
        .inj_o  (inj_o)
    );

    // R4
    disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !inj_en_i |-> (inj_o == orig_i));

endmodule

// File: tb/net_fiu_tb.sv
`timescale 1ns/1ps
module net_fiu_tb;
    import fiu_pkg::*;

    localparam logic [7:0] MASK = 8'b0010_0101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       orig = 1'b0;
    logic       chain_i = 1'b0;
    logic       shift_en = 1'b0;
    logic       update = 1'b0;
    logic       phase = 1'b0;
    logic       inj_en = 1'b0;
    logic [7:0] lfsr = 8'h00;
    logic       inj_o, chain_o, inj_lim, chain_lim;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [5:0] sh_m, pat_m;
    logic       dly_m;
    logic [2:0] prev_m;
    string      ctx = "";

    always #10 clk = ~clk;

    net_fiu #(.LFSR_W(8), .SOPEN_MASK(MASK), .ONLY_MODEL(F_NONE)) u_dut (
        .clk(clk), .rst(rst), .orig_i(orig), .inj_o(inj_o), .chain_i(chain_i),
        .shift_en_i(shift_en), .chain_o(chain_o), .update_i(update),
        .phase_i(phase), .inj_en_i(inj_en), .lfsr_i(lfsr)
    );

    net_fiu #(.LFSR_W(8), .SOPEN_MASK(8'h00), .ONLY_MODEL(F_SOPEN)) u_dut_lim (
        .clk(clk), .rst(rst), .orig_i(orig), .inj_o(inj_lim), .chain_i(chain_i),
        .shift_en_i(shift_en), .chain_o(chain_lim), .update_i(update),
        .phase_i(phase), .inj_en_i(inj_en), .lfsr_i(lfsr)
    );

    function automatic logic model_out(logic [2:0] c, logic o, logic d, logic first, logic [7:0] l);
        case (c)
            3'd1:    return 1'b0;
            3'd2:    return 1'b1;
            3'd3:    return d;
            3'd4:    return first ? ~o : o;
            3'd5:    return &(l | ~MASK);
            default: return o;
        endcase
    endfunction

    function automatic string tag_for(logic en, logic [2:0] c);
        if (!en) return "R4";
        case (c)
            3'd1, 3'd2: return "R6";
            3'd3:       return "R7";
            3'd4:       return "R8";
            3'd5:       return "R9";
            default:    return "R5";
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic [2:0] sel, eff;
        logic       first;
        logic [5:0] old_sh;
        #1;
        sel   = phase ? pat_m[5:3] : pat_m[2:0];
        eff   = inj_en ? sel : 3'd0;
        first = (eff == 3'd4) && (prev_m != 3'd4);
        chk((ctx != "") ? ctx : tag_for(inj_en, eff), inj_o, model_out(eff, orig, dly_m, first, lfsr));
        chk("R2", chain_o, sh_m[5]);
        // R10 and R9 (empty mask): only stuck-open acts, giving constant 1
        chk("R10", inj_lim, (eff == 3'd5) ? 1'b1 : orig);
        @(posedge clk);
        old_sh = sh_m;
        if (update) pat_m = old_sh;
        if (shift_en) sh_m = {old_sh[4:0], chain_i};
        dly_m  = orig;
        prev_m = eff;
        @(negedge clk);
    endtask

    task automatic load(logic [5:0] v);
        for (int i = 5; i >= 0; i--) begin
            chain_i  = v[i];
            shift_en = 1'b1;
            step();
        end
        shift_en = 1'b0;
        update   = 1'b1;
        step();
        update   = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        sh_m = '0; pat_m = '0; dly_m = 1'b0; prev_m = 3'd0;
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, both phases enabled
        ctx = "R1"; inj_en = 1'b1;
        chk("R1", chain_o, 1'b0);
        for (int i = 0; i < 4; i++) begin
            phase = i[0]; orig = i[1];
            step();
        end
        ctx = "";

        // delay in phase 1, bit flip in phase 2
        load(6'b100_011);
        phase = 1'b0;
        for (int i = 0; i < 6; i++) begin orig = i[0]; step(); end
        phase = 1'b1;
        for (int i = 0; i < 4; i++) begin orig = i[1]; step(); end
        phase = 1'b0; step();
        phase = 1'b1; orig = 1'b1; step(); step();
        inj_en = 1'b0; step();
        inj_en = 1'b1; step(); step();

        // stuck-at and stuck-open
        load(6'b010_001);
        for (int i = 0; i < 4; i++) begin phase = i[0]; orig = ~i[1]; step(); end
        load(6'b101_010);
        for (int i = 0; i < 8; i++) begin
            phase = 1'b1; lfsr = 8'($urandom); orig = i[0]; step();
        end
        lfsr = 8'hFF; step(); lfsr = 8'hDA; step();

        // R3: shift new bits without update, active stuck-at-1 stays
        phase = 1'b0; ctx = "R3";
        for (int i = 0; i < 6; i++) begin
            shift_en = 1'b1; chain_i = 1'b0; orig = 1'b0; step();
        end
        shift_en = 1'b0; step();
        ctx = "";

        // R11: shift and update together capture pre-shift content
        for (int i = 0; i < 5; i++) begin shift_en = 1'b1; chain_i = 1'b1; step(); end
        update = 1'b1; chain_i = 1'b0; step();
        update = 1'b0; shift_en = 1'b0; ctx = "R11";
        orig = 1'b0; phase = 1'b0; step(); phase = 1'b1; step();
        ctx = "";

        // R5: reserved codes
        load(6'b111_110);
        for (int i = 0; i < 4; i++) begin phase = i[0]; orig = i[1]; step(); end

        // R4: disabled with active faults
        load(6'b001_010);
        inj_en = 1'b0;
        for (int i = 0; i < 4; i++) begin phase = i[0]; orig = i[1]; step(); end
        inj_en = 1'b1;

        // random mix
        for (int i = 0; i < 3000; i++) begin
            shift_en = ($urandom % 2) == 0;
            chain_i  = 1'($urandom);
            update   = ($urandom % 8) == 0;
            phase    = ($urandom % 4) == 0 ? ~phase : phase;
            inj_en   = ($urandom % 10) != 0;
            orig     = 1'($urandom);
            lfsr     = 8'($urandom);
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule